// File: doc/BRIEF.md
# Serial Boot Command Handshake Responder

This block runs the opening exchange of a serial boot-loader session. It sits between a byte receiver and a byte transmitter. When the link layer reports that the session is set up, the block first turns on reception. It then offers a single go-ahead byte, 30H, to the transmitter. After that it waits for a command byte and checks it against a parameter table of accepted codes. It answers every command byte with one acknowledge byte.

A good command is echoed back. The RAM-transfer command (10H) is always accepted, and once its echo has left, the block raises a sticky branch output that hands the session to the next phase. A receive error is answered with low nibble 8H, and an unknown code with low nibble 1H. In both of these replies the high nibble repeats the high nibble of the last cleanly received command. After either error reply the block waits for another command. When the link runs in synchronous I/O mode, the receive error flag is not looked at.

Both byte paths use valid/ready. A received byte is taken only on a cycle where `rx_valid` and `rx_ready` are both high. An offered byte stays on `tx_data`, with `tx_valid` high, until a cycle where `tx_ready` is high. The transmitter may hold `tx_ready` low for as long as it likes. While a reply is waiting, `rx_ready` stays low, so the sender is held off.

Top module: `boot_cmd_responder`

## Requirements
- R1: After reset, `tx_valid`, `rx_ready`, `rx_en` and `branch_ram` are all 0, and the stored last-command byte is 00H.
- R2: A high `link_up` in the idle state sets `rx_en` on the next edge. One edge later, `tx_valid` rises with `tx_data` = 30H. `rx_en` then stays high until reset.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change. A byte is handed over only on an edge where both are high.
- R4: `rx_ready` is high only while the block waits for a command and no byte is offered on `tx_data`. A byte presented while `rx_ready` is low is not taken.
- R5: A command byte in the accepted table, with no receive error counted, is offered back unchanged on the edge that takes it. After that reply is handed over, the block waits for the next command.
- R6: A command byte not in the table, with no receive error counted, is answered with {last[7:4], 1H}.
- R7: In asynchronous mode (`sync_mode` = 0), a command byte taken with `rx_err` = 1 is answered with {last[7:4], 8H}, whatever its code. The error takes precedence over the table check.
- R8: The stored last-command byte takes the value of every command byte accepted without a counted receive error, valid or not. A byte with a counted receive error leaves it unchanged.
- R9: With `sync_mode` = 1, `rx_err` is ignored, and the byte is handled as in R5 or R6.
- R10: Code 10H is always accepted. Once its echo is handed over, `branch_ram` goes to 1 and stays 1, and `rx_ready` stays 0 until reset.
- R11: The accepted table is the parameter list CMD_LIST. The default list is 10H, 18H, 20H and A5H.
- R12: `link_up` is ignored outside the idle state. It produces no further go-ahead byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Session set-up done; starts the handshake from idle |
| sync_mode | input | 1 | 1 = synchronous I/O link, receive errors not checked |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block will take a command byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error on the presented byte |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_data | output | 8 | Offered byte |
| rx_en | output | 1 | Receiver enable |
| branch_ram | output | 1 | Sticky hand-over to the RAM-transfer phase |

## Verification
The bench sends every one of the 256 command codes without error. A table decode that is off by one bit, or a 10H that is not forced valid, shows up as an echo where a 1H reply was due, or the other way round. Errored bytes are sent on both valid and invalid codes and in both modes. A design that checks the table first, checks errors in synchronous mode, or lets an errored byte update the stored command would put the wrong high or low nibble on the reply. The go-ahead byte is held off by the transmitter to catch data that changes, a reply that is dropped, or a command taken while a reply is pending. The final checks cover a branch that is not sticky, `rx_en` arriving late, and a late `link_up` that replays the go-ahead byte.

// File: rtl/bootrsp_pkg.sv
package bootrsp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam byte_t GO_AHEAD   = 8'h30;
  localparam byte_t RAM_XFER   = 8'h10;
  localparam nib_t  NAK_RXERR  = 4'h8;
  localparam nib_t  NAK_BADCMD = 4'h1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_GO, ST_CMD, ST_ACK, ST_RUN
  } state_t;
endpackage

// File: rtl/bootrsp_cmd_match.sv
module bootrsp_cmd_match
  import bootrsp_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter logic [NUM_CMDS*BYTE_W-1:0] CMD_LIST = {8'hA5, 8'h20, 8'h18, 8'h10}
) (
  input  byte_t code,
  output logic  hit
);
  logic [NUM_CMDS-1:0] lane_hit;

  generate
    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_lane
      assign lane_hit[i] = (code == CMD_LIST[i*BYTE_W +: BYTE_W]);
    end
  endgenerate

  // the RAM-transfer code is a member no matter what the list holds
  assign hit = (|lane_hit) || (code == RAM_XFER);
endmodule

// File: rtl/bootrsp_reply_form.sv
module bootrsp_reply_form
  import bootrsp_pkg::*;
(
  input  byte_t code,
  input  logic  err,
  input  logic  hit,
  input  nib_t  last_hi,
  output byte_t reply,
  output logic  keep_code
);
  always_comb begin
    if (err)       reply = {last_hi, NAK_RXERR};
    else if (!hit) reply = {last_hi, NAK_BADCMD};
    else           reply = code;
    keep_code = !err;
  end
endmodule

// File: rtl/bootrsp_tx_hold.sv
module bootrsp_tx_hold
  import bootrsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_data,
  output logic  tx_valid,
  input  logic  tx_ready,
  output byte_t tx_data,
  output logic  taken
);
  assign taken = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (taken) begin
      tx_valid <= 1'b0;
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R3
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !tx_valid); // R3
endmodule

// File: rtl/boot_cmd_responder.sv
module boot_cmd_responder
  import bootrsp_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter logic [NUM_CMDS*BYTE_W-1:0] CMD_LIST = {8'hA5, 8'h20, 8'h18, 8'h10}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              sync_mode,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              rx_en,
  output logic              branch_ram
);
  state_t state;
  byte_t  last_cmd;
  logic   run_next;
  logic   hit, err_eff, keep_code, rx_fire, load, taken;
  byte_t  reply, load_data;

  bootrsp_cmd_match #(.NUM_CMDS(NUM_CMDS), .CMD_LIST(CMD_LIST)) u_match (
    .code(rx_data), .hit(hit)
  );

  assign err_eff = rx_err && !sync_mode;

  bootrsp_reply_form u_form (
    .code(rx_data), .err(err_eff), .hit(hit),
    .last_hi(last_cmd[BYTE_W-1 -: NIB_W]),
    .reply(reply), .keep_code(keep_code)
  );

  assign rx_ready   = (state == ST_CMD);
  assign rx_fire    = rx_valid && rx_ready;
  assign branch_ram = (state == ST_RUN);
  assign load       = (state == ST_ARM) || rx_fire;
  assign load_data  = (state == ST_ARM) ? GO_AHEAD : reply;

  bootrsp_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .taken(taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      last_cmd <= '0;
      rx_en    <= 1'b0;
      run_next <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (link_up) begin
          rx_en <= 1'b1;
          state <= ST_ARM;
        end
        ST_ARM:  state <= ST_GO;
        ST_GO:   if (taken) state <= ST_CMD;
        ST_CMD:  if (rx_fire) begin
          if (keep_code) last_cmd <= rx_data;
          run_next <= !err_eff && (rx_data == RAM_XFER);
          state    <= ST_ACK;
        end
        ST_ACK:  if (taken) state <= run_next ? ST_RUN : ST_CMD;
        ST_RUN:  state <= ST_RUN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RX_EN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> rx_en); // R2
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !tx_valid); // R4
  AST_ERR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rx_err && !sync_mode) |=> (tx_valid && tx_data[NIB_W-1:0] == NAK_RXERR)); // R7
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    branch_ram |=> (branch_ram && !rx_ready)); // R10
endmodule

// File: tb/boot_cmd_responder_test.sv
module boot_cmd_responder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0, sync_mode = 1'b0;
  logic rx_valid = 1'b0, rx_err = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, rx_en, branch_ram;
  logic [7:0] tx_data;
  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] last = 8'h00;

  always #4 clk = ~clk;

  boot_cmd_responder uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .sync_mode(sync_mode),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_en(rx_en), .branch_ram(branch_ram)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_table(logic [7:0] b);
    return b == 8'h10 || b == 8'h18 || b == 8'h20 || b == 8'hA5;
  endfunction

  // send one command byte and check the reply offered on the taking edge
  task automatic send_cmd(logic [7:0] b, logic err, string req);
    logic [7:0] exp;
    bit counted;
    counted = err && !sync_mode;
    if (counted)          exp = {last[7:4], 4'h8};
    else if (!in_table(b)) exp = {last[7:4], 4'h1};
    else                  exp = b;
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_err = err;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
    check({req, " reply valid"}, {7'd0, tx_valid}, 8'd1);
    check({req, " reply"}, tx_data, exp);
    check("R4 rx_ready low while reply pending", {7'd0, rx_ready}, 8'd0);
    if (!counted) last = b;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; failures++;
      $display("FAIL R4 watchdog actual=stalled expected=progress");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
    check("R1 rx_ready", {7'd0, rx_ready}, 8'd0);
    check("R1 rx_en", {7'd0, rx_en}, 8'd0);
    check("R1 branch_ram", {7'd0, branch_ram}, 8'd0);

    link_up = 1'b1;
    @(negedge clk);
    link_up = 1'b0;
    check("R2 rx_en set first", {7'd0, rx_en}, 8'd1);
    check("R2 no byte yet", {7'd0, tx_valid}, 8'd0);
    @(negedge clk);
    check("R2 go-ahead valid", {7'd0, tx_valid}, 8'd1);
    check("R2 go-ahead byte", tx_data, 8'h30);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 held valid", {7'd0, tx_valid}, 8'd1);
      check("R3 held data", tx_data, 8'h30);
      check("R4 no rx while offering", {7'd0, rx_ready}, 8'd0);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    check("R3 released", {7'd0, tx_valid}, 8'd0);
    check("R2 rx_en stays", {7'd0, rx_en}, 8'd1);

    link_up = 1'b1;
    repeat (3) @(negedge clk);
    link_up = 1'b0;
    check("R12 no replay", {7'd0, tx_valid}, 8'd0);

    // errored byte first: high nibble from reset value 00H
    send_cmd(8'h77, 1'b1, "R1 R7 R8 reset last");
    send_cmd(8'h20, 1'b1, "R7 error beats table");
    for (int b = 0; b < 256; b++)
      if (b != 16) send_cmd(8'(b), 1'b0, in_table(8'(b)) ? "R5 R11 echo" : "R6 R8 bad code");
    for (int i = 0; i < 16; i++) send_cmd(8'(i * 17), 1'b1, "R7 R8 rx error");
    sync_mode = 1'b1;
    for (int i = 0; i < 16; i++) send_cmd(8'(i * 17 + 1), 1'b1, "R9 error ignored");
    send_cmd(8'hA5, 1'b1, "R9 sync valid");
    sync_mode = 1'b0;
    send_cmd(8'h10, 1'b1, "R7 errored 10H no branch");
    check("R7 no branch", {7'd0, branch_ram}, 8'd0);
    send_cmd(8'h10, 1'b0, "R10 echo 10H");
    check("R10 branch up", {7'd0, branch_ram}, 8'd1);
    rx_valid = 1'b1; rx_data = 8'h20;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R10 branch sticky", {7'd0, branch_ram}, 8'd1);
      check("R10 rx closed", {7'd0, rx_ready}, 8'd0);
      check("R10 nothing sent", {7'd0, tx_valid}, 8'd0);
    end
    rx_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule